// File: doc/BRIEF.md
# Three-Input Truth-Table Logic Unit

This block evaluates an arbitrary bitwise Boolean function of three operands. An 8-bit truth table is supplied alongside the operands, so any of the 256 possible three-input functions can be picked per operation. Every bit position is evaluated on its own. The three operand bits at that position form a 3-bit index, and the table bit at that index becomes the result bit.

Two table inputs are offered, because the table arrives in a different field depending on the operation form. A form-select input picks which table is used. The result is registered and marked by a one-cycle valid strobe. Zero and sign flags are refreshed from the new result only when the caller asks for it.

Top module: `lut3_logic_unit`

## Requirements
- R1: After reset, `outValid` is 0, `result` is 0, and both `zeroFlag` and `signFlag` are 0.
- R2: For each bit i, the index is {opA[i], opB[i], opC[i]}, with opA as index bit 2, opB as index bit 1 and opC as index bit 0. The result bit i is bit `index` of the selected table.
- R3: When `formSel` is 1, the table is taken from `regTable`. When `formSel` is 0, it is taken from `altTable`.
- R4: `outValid` is 1 in exactly the cycle after a cycle in which `inValid` was 1, and 0 otherwise. The new `result` is visible in that same cycle.
- R5: When `inValid` is 0, `result` keeps its previous value, whatever the other inputs do.
- R6: The flags are updated only by an accepted operation with `flagEn` = 1. Otherwise they keep their previous values.
- R7: On an update, `zeroFlag` is 1 exactly when the new result is all zeros, and `signFlag` equals its most significant bit.
- R8: Table 0xF0 returns opA, 0xCC returns opB, 0xAA returns opC, 0x96 returns opA^opB^opC, 0x00 returns all zeros and 0xFF returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation accepted this cycle |
| formSel | input | 1 | 1 selects regTable, 0 selects altTable |
| flagEn | input | 1 | Update the flags from this operation |
| opA | input | 32 | Operand supplying index bit 2 |
| opB | input | 32 | Operand supplying index bit 1 |
| opC | input | 32 | Operand supplying index bit 0 |
| regTable | input | 8 | Truth table used in register form |
| altTable | input | 8 | Truth table used in the other forms |
| outValid | output | 1 | Result updated this cycle |
| result | output | 32 | Registered function result |
| zeroFlag | output | 1 | Last flagged result was zero |
| signFlag | output | 1 | Most significant bit of the last flagged result |

## Verification
The bench builds the block with its default 32-bit width, so the sign flag is bit 31 of the result.

It sweeps all 256 tables with operands 0xF0F0F0F0, 0xCCCCCCCC and 0xAAAAAAAA. With those operands each result byte replays the table itself, which exposes any swap in the index order or a table bit that is never reached.

Directed steps cover form selection, holds on idle cycles, and flag suppression when `flagEn` is 0.

// File: rtl/lut3_pkg.sv
package lut3_pkg;
  typedef struct packed {
    logic loadResult;
    logic loadFlags;
  } lut3Strobe_t;
endpackage

// File: rtl/lut3_ctrl.sv
module lut3_ctrl
  import lut3_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        flagEn,
  output lut3Strobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.loadResult = inValid;
    strobe.loadFlags  = inValid & flagEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  assert_valid_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/lut3_datapath.sv
module lut3_datapath
  import lut3_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lut3Strobe_t      strobe,
  input  logic             formSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [7:0]       regTable,
  input  logic [7:0]       altTable,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             signFlag
);
  localparam int MSB = WIDTH - 1;

  logic [7:0]       selTable;
  logic [WIDTH-1:0] nextResult;

  assign selTable = formSel ? regTable : altTable;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [2:0] idx;
    assign idx           = {opA[i], opB[i], opC[i]};
    assign nextResult[i] = selTable[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      zeroFlag <= 1'b0;
      signFlag <= 1'b0;
    end else begin
      if (strobe.loadResult) result <= nextResult;
      if (strobe.loadFlags) begin
        zeroFlag <= (nextResult == '0);
        signFlag <= nextResult[MSB];
      end
    end
  end

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadResult |=> $stable(result));
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadFlags |=> ($stable(zeroFlag) && $stable(signFlag)));
  assert_zero_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadFlags |=> (zeroFlag == (result == '0)));
  assert_sign_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadFlags |=> (signFlag == result[MSB]));
  assert_pass_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadResult && selTable == 8'hF0) |=> (result == $past(opA)));
endmodule

// File: rtl/lut3_logic_unit.sv
module lut3_logic_unit
  import lut3_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             formSel,
  input  logic             flagEn,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [7:0]       regTable,
  input  logic [7:0]       altTable,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             signFlag
);
  lut3Strobe_t strobe;

  lut3_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .flagEn(flagEn),
    .strobe(strobe), .outValid(outValid)
  );

  lut3_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .formSel(formSel),
    .opA(opA), .opB(opB), .opC(opC), .regTable(regTable), .altTable(altTable),
    .result(result), .zeroFlag(zeroFlag), .signFlag(signFlag)
  );
endmodule

// File: tb/lut3_logic_unit_bench.sv
module lut3_logic_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, formSel = 1'b0, flagEn = 1'b0;
  logic [31:0] opA = '0, opB = '0, opC = '0;
  logic [7:0] regTable = '0, altTable = '0;
  logic outValid, zeroFlag, signFlag;
  logic [31:0] result;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  lut3_logic_unit u_lut3_logic_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .formSel(formSel), .flagEn(flagEn),
    .opA(opA), .opB(opB), .opC(opC), .regTable(regTable), .altTable(altTable),
    .outValid(outValid), .result(result), .zeroFlag(zeroFlag), .signFlag(signFlag)
  );

  // vectors: a, b, c, regTable, altTable, formSel, flagEn
  localparam int NV = 8;
  localparam logic [31:0] VA [NV] = '{32'h12345678, 32'hFFFF0000, 32'h0F0F0F0F, 32'hDEADBEEF,
                                      32'h00000000, 32'hA5A5A5A5, 32'h80000001, 32'h13579BDF};
  localparam logic [31:0] VB [NV] = '{32'h9ABCDEF0, 32'hFF00FF00, 32'h33333333, 32'hCAFEF00D,
                                      32'h00000000, 32'h5A5A5A5A, 32'h7FFFFFFE, 32'h2468ACE0};
  localparam logic [31:0] VC [NV] = '{32'h0F1E2D3C, 32'hF0F0F0F0, 32'h55555555, 32'h01234567,
                                      32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'hFEDCBA98};
  localparam logic [7:0]  VR [NV] = '{8'hF0, 8'h00, 8'hE8, 8'h96, 8'h01, 8'h3C, 8'h80, 8'hCC};
  localparam logic [7:0]  VT [NV] = '{8'h00, 8'hCC, 8'h11, 8'h00, 8'h00, 8'hAA, 8'hFE, 8'h5A};
  localparam logic        VF [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        VE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  function automatic logic [31:0] refFn(input logic [31:0] a, b, c, input logic [7:0] t);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = t[{a[i], b[i], c[i]}];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one accepted operation, then sample after the capturing edge
  task automatic doOp(input logic [31:0] a, b, c, input logic [7:0] rt, at,
                      input logic fs, fe);
    @(negedge clk);
    opA = a; opB = b; opC = c; regTable = rt; altTable = at;
    formSel = fs; flagEn = fe; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 flags", {30'b0, zeroFlag, signFlag}, 32'd0);
    rst_n = 1'b1;

    // vector table: R2, R3, R4, R7
    for (int v = 0; v < NV; v++) begin
      doOp(VA[v], VB[v], VC[v], VR[v], VT[v], VF[v], VE[v]);
      exp = refFn(VA[v], VB[v], VC[v], VF[v] ? VR[v] : VT[v]);
      check("R2/R3 result", result, exp);
      check("R4 outValid", {31'b0, outValid}, 32'd1);
      check("R7 zeroFlag", {31'b0, zeroFlag}, {31'b0, exp == 32'd0});
      check("R7 signFlag", {31'b0, signFlag}, {31'b0, exp[31]});
    end
    @(negedge clk);
    check("R4 outValid low when idle", {31'b0, outValid}, 32'd0);

    // R2 sweep of all tables: each byte of the result reproduces the table
    for (int t = 0; t < 256; t++) begin
      doOp(32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA, t[7:0], ~t[7:0], 1'b1, 1'b0);
      check("R2 sweep", result, {4{t[7:0]}});
    end

    // R8 named functions (altTable path, formSel=0)
    doOp(32'h11223344, 32'h55667788, 32'h99AABBCC, 8'h00, 8'hF0, 1'b0, 1'b0);
    check("R8 pass a", result, 32'h11223344);
    doOp(32'h11223344, 32'h55667788, 32'h99AABBCC, 8'h00, 8'hCC, 1'b0, 1'b0);
    check("R8 pass b", result, 32'h55667788);
    doOp(32'h11223344, 32'h55667788, 32'h99AABBCC, 8'h00, 8'hAA, 1'b0, 1'b0);
    check("R8 pass c", result, 32'h99AABBCC);
    doOp(32'h11223344, 32'h55667788, 32'h99AABBCC, 8'h96, 8'h00, 1'b1, 1'b0);
    check("R8 xor3", result, 32'h11223344 ^ 32'h55667788 ^ 32'h99AABBCC);
    doOp(32'h11223344, 32'h55667788, 32'h99AABBCC, 8'hFF, 8'h00, 1'b1, 1'b0);
    check("R8 ones", result, 32'hFFFFFFFF);

    // R3 same operands, only formSel differs
    doOp(32'hAAAA5555, 32'h0, 32'h0, 8'hF0, 8'h0F, 1'b0, 1'b0);
    check("R3 altTable chosen", result, 32'h5555AAAA);

    // R6 set known flags: zero result with flagEn
    doOp(32'h1, 32'h2, 32'h3, 8'h00, 8'h00, 1'b1, 1'b1);
    check("R7 zero set", {30'b0, zeroFlag, signFlag}, 32'd2);
    // R6 negative result without flagEn: flags must hold
    doOp(32'h80000000, 32'h0, 32'h0, 8'hF0, 8'h00, 1'b1, 1'b0);
    check("R6 result updated", result, 32'h80000000);
    check("R6 flags held", {30'b0, zeroFlag, signFlag}, 32'd2);
    doOp(32'h80000000, 32'h0, 32'h0, 8'hF0, 8'h00, 1'b1, 1'b1);
    check("R6 flags updated", {30'b0, zeroFlag, signFlag}, 32'd1);

    // R5 idle inputs change, no accept: result and flags hold
    held = result;
    @(negedge clk);
    opA = 32'h0; regTable = 8'hFF; altTable = 8'hFF; flagEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 result held", result, held);
    check("R5 flags held", {30'b0, zeroFlag, signFlag}, 32'd1);
    check("R4 no valid", {31'b0, outValid}, 32'd0);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset result", result, 32'd0);
    check("R1 reset flags", {30'b0, zeroFlag, signFlag}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule